// File: doc/BRIEF.md
# Contact Card Power Sequencer

This block orders the powering up and powering down of a contact smart card on behalf of a host. While idle it filters the card-presence switch and reports on an active-low status line whether a card is seated. When the host pulls its start command low with a card present and no fault pending, the block walks a half-unit phase counter and releases the booster, the card supply, the data lines, the card clock and the card reset one after another. The host's reset request decides when the card clock starts.

The time unit T is 2 × `HALF_T_TICKS` pulses of a slow timebase tick, which is 64 oscillator periods at the default. When the host raises its start command, the block runs the sequence in reverse and returns to idle. A fault or a card removal does the same, and the status line then drops and stays low until the host raises its start command again. A synchronous power-on-reset input holds everything in the idle state.

Top module: `card_seq_top`

## Requirements
- R1: While `rst_n` is low, or on the cycle after any edge that samples `por_act` high, all five enables are 0 and `off_n` is 0. The debounced presence is cleared and has to be re-earned after such a reset.
- R2: `off_n` outside a session rises only after `card_raw` has been high at `DEBOUNCE_TICKS` consecutive tick edges. It falls on the cycle after the first edge that samples `card_raw` low.
- R3: Starting requires the idle state, `start_n` low, debounced presence and all `fault_in` bits zero. `booster_en` is high from the next cycle, and `vcc_en` rises when 0.5T of ticks has elapsed since the start.
- R4: `data_en` rises at 4T after the start. From 7T, `card_rst` equals `rst_req` combinationally.
- R5: The card clock starts at the first cycle at or after 4T in which `rst_req` is low, and at 7T at the latest. Once started, it stays on for the rest of the session, whatever `rst_req` does.
- R6: Deactivation begins on the edge that samples `start_n` high. In the same cycle `card_rst` goes low. The clock stops at 0.5T, `data_en` falls at 1T and `vcc_en` falls at 1.5T. `booster_en` falls at 5T, and the block is idle one cycle later. An output that was never enabled stays low throughout.
- R7: In a session, a nonzero `fault_in` bit or a sampled loss of presence starts the same deactivation on the next edge and drives `off_n` low. `off_n` stays low until an edge in the idle state samples `start_n` high.
- R8: A start command during deactivation does not re-enable anything until idle is reached. If `start_n` is still low at that point, a new activation starts on the following edge.
- R9: The enables stay ordered at all times: `vcc_en` implies `booster_en`, `data_en` implies `vcc_en`, `clk_en` implies `data_en`, and `card_rst` implies `clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_act | input | 1 | Synchronous power-on reset hold, active high |
| tick | input | 1 | One-cycle timebase pulse, one per oscillator period |
| start_n | input | 1 | Host start command, active low |
| rst_req | input | 1 | Host reset request for the card |
| card_raw | input | 1 | Raw presence switch, high when a card is seated |
| fault_in | input | NUM_FAULTS | Fault flags: overcurrent, overtemperature, supply drop |
| booster_en | output | 1 | Booster enable |
| vcc_en | output | 1 | Card supply enable |
| data_en | output | 1 | Data lines released from forced low |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset level |
| off_n | output | 1 | Host status and interrupt, active low |

## Verification
All outputs are decoded combinationally from registered state, so each result of an input sampled at a rising edge is due in the cycle that follows that edge. The exceptions are `clk_en` and `card_rst`, which also follow `rst_req` within the same cycle. Each phase boundary lands n × `HALF_T_TICKS` ticks after the edge that entered the state, so the interval depends on how the ticks are spaced, not on a fixed cycle count. The bench updates a reference model at each rising edge from the same inputs, and compares every output with it at the falling edge, before it drives new inputs. A threshold crossing is therefore checked in the exact cycle it is due.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  localparam int PHASE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SESS = 2'd1,
    ST_DEAC = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic boost;
    logic vcc;
    logic data;
    logic clk;
    logic rst;
  } card_en_t;

  // Activation milestones, in half-units of T since the start
  localparam logic [PHASE_W-1:0] PH_VCC_ON    = 4'd1;
  localparam logic [PHASE_W-1:0] PH_DATA_ON   = 4'd8;
  localparam logic [PHASE_W-1:0] PH_RST_ON    = 4'd14;
  // Deactivation milestones, in half-units of T since the stop
  localparam logic [PHASE_W-1:0] PH_CLK_OFF   = 4'd1;
  localparam logic [PHASE_W-1:0] PH_DATA_OFF  = 4'd2;
  localparam logic [PHASE_W-1:0] PH_VCC_OFF   = 4'd3;
  localparam logic [PHASE_W-1:0] PH_BOOST_OFF = 4'd10;
  localparam logic [PHASE_W-1:0] PH_MAX       = 4'd15;

  // The clock may start once the data lines are free and the host reset is low;
  // at the reset milestone it starts regardless.
  function automatic logic clk_start_ok(input logic [PHASE_W-1:0] ph, input logic rst_req);
    return (ph >= PH_DATA_ON) && (!rst_req || (ph >= PH_RST_ON));
  endfunction

  function automatic card_en_t sess_enables(input logic [PHASE_W-1:0] ph,
                                            input logic latch, input logic rst_req);
    card_en_t e;
    e.boost = 1'b1;
    e.vcc   = (ph >= PH_VCC_ON);
    e.data  = (ph >= PH_DATA_ON);
    e.clk   = latch | clk_start_ok(ph, rst_req);
    e.rst   = (ph >= PH_RST_ON) & rst_req;
    return e;
  endfunction

  function automatic card_en_t deac_enables(input logic [PHASE_W-1:0] ph,
                                            input logic [PHASE_W-1:0] entry,
                                            input logic latch);
    card_en_t e;
    e.boost = (ph < PH_BOOST_OFF);
    e.vcc   = (entry >= PH_VCC_ON) && (ph < PH_VCC_OFF);
    e.data  = (entry >= PH_DATA_ON) && (ph < PH_DATA_OFF);
    e.clk   = latch && (ph < PH_CLK_OFF);
    e.rst   = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/card_presence_filter.sv
module card_presence_filter #(
  parameter int DEBOUNCE_TICKS = 20480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic raw,
  output logic present
);
  localparam int CNT_W = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  // Insertion waits out the full window; removal is taken at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      present <= 1'b0;
    end else if (clr || !raw) begin
      cnt     <= '0;
      present <= 1'b0;
    end else if (!present && tick) begin
      if (cnt == LAST) present <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_phase_timer.sv
module card_phase_timer
  import card_seq_pkg::*;
#(
  parameter int HALF_T_TICKS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  output logic [PHASE_W-1:0] phase
);
  localparam int SUB_W = $clog2(HALF_T_TICKS + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_T_TICKS - 1);

  logic [SUB_W-1:0] sub;
  logic             half_done;

  assign half_done = tick && (sub == SUB_LAST) && (phase != PH_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub   <= '0;
      phase <= '0;
    end else if (restart) begin
      sub   <= '0;
      phase <= '0;
    end else if (half_done) begin
      sub   <= '0;
      phase <= phase + 1'b1;
    end else if (tick && phase != PH_MAX) begin
      sub   <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               start_n,
  input  logic               rst_req,
  input  logic               present,
  input  logic               fault_any,
  input  logic [PHASE_W-1:0] phase,
  output logic               restart,
  output card_en_t           en,
  output logic               off_n,
  output logic               in_session,
  output logic               in_deact
);
  seq_state_e         state;
  logic               clk_latch;
  logic               flt_latch;
  logic [PHASE_W-1:0] entry_phase;

  logic start_evt, emerg_evt, stop_evt, done_evt;

  assign in_session = (state == ST_SESS);
  assign in_deact   = (state == ST_DEAC);
  assign start_evt  = (state == ST_IDLE) && !start_n && present && !fault_any;
  assign emerg_evt  = in_session && (fault_any || !present);
  assign stop_evt   = in_session && (start_n || fault_any || !present);
  assign done_evt   = in_deact && (phase >= PH_BOOST_OFF);
  assign restart    = start_evt || stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      clk_latch   <= 1'b0;
      flt_latch   <= 1'b0;
      entry_phase <= '0;
    end else if (clr) begin
      state       <= ST_IDLE;
      clk_latch   <= 1'b0;
      flt_latch   <= 1'b0;
      entry_phase <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          clk_latch <= 1'b0;
          if (start_n)   flt_latch <= 1'b0;
          if (start_evt) state     <= ST_SESS;
        end
        ST_SESS: begin
          clk_latch <= clk_latch | clk_start_ok(phase, rst_req);
          if (stop_evt) begin
            state       <= ST_DEAC;
            entry_phase <= phase;
          end
          if (emerg_evt) flt_latch <= 1'b1;
        end
        ST_DEAC: begin
          if (done_evt) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    en = '0;
    unique case (state)
      ST_SESS: en = sess_enables(phase, clk_latch, rst_req);
      ST_DEAC: en = deac_enables(phase, entry_phase, clk_latch);
      default: en = '0;
    endcase
  end

  assign off_n = present && !flt_latch;
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
  import card_seq_pkg::*;
#(
  parameter int HALF_T_TICKS   = 32,
  parameter int DEBOUNCE_TICKS = 20480,
  parameter int NUM_FAULTS     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_act,
  input  logic                  tick,
  input  logic                  start_n,
  input  logic                  rst_req,
  input  logic                  card_raw,
  input  logic [NUM_FAULTS-1:0] fault_in,
  output logic                  booster_en,
  output logic                  vcc_en,
  output logic                  data_en,
  output logic                  clk_en,
  output logic                  card_rst,
  output logic                  off_n
);
  logic               present;
  logic               fault_any;
  logic               restart;
  logic               in_session;
  logic               in_deact;
  logic [PHASE_W-1:0] phase;
  card_en_t           en;

  assign fault_any = |fault_in;

  card_presence_filter #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_pres (
    .clk(clk), .rst_n(rst_n), .clr(por_act), .tick(tick),
    .raw(card_raw), .present(present)
  );

  card_phase_timer #(.HALF_T_TICKS(HALF_T_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart || por_act),
    .tick(tick), .phase(phase)
  );

  card_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(por_act), .start_n(start_n),
    .rst_req(rst_req), .present(present), .fault_any(fault_any),
    .phase(phase), .restart(restart), .en(en), .off_n(off_n),
    .in_session(in_session), .in_deact(in_deact)
  );

  assign booster_en = en.boost;
  assign vcc_en     = en.vcc;
  assign data_en    = en.data;
  assign clk_en     = en.clk;
  assign card_rst   = en.rst;
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk #(
  parameter int NF = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_act,
  input logic [NF-1:0] fault_in,
  input logic          booster_en,
  input logic          vcc_en,
  input logic          data_en,
  input logic          clk_en,
  input logic          card_rst,
  input logic          off_n,
  input logic          in_session,
  input logic          in_deact
);
  assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    por_act |=> (!booster_en && !off_n));

  assert_vcc_rise_in_session_R3: assert property (@(posedge clk) disable iff (!rst_n || por_act)
    $rose(vcc_en) |-> in_session);

  assert_fault_stops_R7: assert property (@(posedge clk) disable iff (!rst_n || por_act)
    (in_session && (fault_in != '0)) |=> (!in_session && !card_rst && !off_n));

  assert_deact_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n || por_act)
    in_deact |=> !$rose(booster_en));

  assert_vcc_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> booster_en);

  assert_data_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> vcc_en);

  assert_clk_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> data_en);

  assert_rst_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);
endmodule

bind card_seq_top card_seq_chk #(.NF(NUM_FAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_act(por_act), .fault_in(fault_in),
  .booster_en(booster_en), .vcc_en(vcc_en), .data_en(data_en),
  .clk_en(clk_en), .card_rst(card_rst), .off_n(off_n),
  .in_session(in_session), .in_deact(in_deact)
);

// File: tb/card_seq_top_tb.sv
`timescale 1ns/1ps
module card_seq_top_tb;
  localparam int HALF = 4;
  localparam int DEB  = 12;
  localparam int NF   = 3;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_act = 1'b0, tick = 1'b0;
  logic start_n = 1'b1, rst_req = 1'b0, card_raw = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic booster_en, vcc_en, data_en, clk_en, card_rst, off_n;

  int checks = 0, failures = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  card_seq_top #(.HALF_T_TICKS(HALF), .DEBOUNCE_TICKS(DEB), .NUM_FAULTS(NF)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_act(por_act), .tick(tick), .start_n(start_n),
    .rst_req(rst_req), .card_raw(card_raw), .fault_in(fault_in),
    .booster_en(booster_en), .vcc_en(vcc_en), .data_en(data_en),
    .clk_en(clk_en), .card_rst(card_rst), .off_n(off_n)
  );

  // Timebase: one tick every TICK_DIV cycles
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0);
  end

  // Reference model: 0 idle, 1 session, 2 deactivating
  int m_st = 0, m_ticks = 0, m_cnt = 0, m_ent = 0;
  bit m_pres = 0, m_flt = 0, m_latch = 0;

  function automatic int halves(input int t);
    return t / HALF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || por_act) begin
      m_st = 0; m_ticks = 0; m_cnt = 0; m_ent = 0;
      m_pres = 0; m_flt = 0; m_latch = 0;
    end else begin
      int h, nst, nt, nc, ne;
      bit np, nf, nl, fa, lost;
      h = halves(m_ticks); fa = (fault_in != '0); lost = !m_pres;
      nst = m_st; nt = m_ticks; nc = m_cnt; ne = m_ent;
      np = m_pres; nf = m_flt; nl = m_latch;
      if (!card_raw) begin np = 0; nc = 0; end
      else if (!m_pres && tick) begin
        if (m_cnt + 1 >= DEB) np = 1; else nc = m_cnt + 1;
      end
      if (tick && m_ticks < 15 * HALF) nt = m_ticks + 1;
      case (m_st)
        0: begin
          nl = 0;
          if (start_n) nf = 0;
          if (!start_n && m_pres && !fa) begin nst = 1; nt = 0; end
        end
        1: begin
          nl = m_latch | (h >= 8 && (!rst_req || h >= 14));
          if (start_n || fa || lost) begin
            nst = 2; nt = 0; ne = h;
            if (fa || lost) nf = 1;
          end
        end
        default: if (h >= 10) nst = 0;
      endcase
      m_st = nst; m_ticks = nt; m_cnt = nc; m_ent = ne;
      m_pres = np; m_flt = nf; m_latch = nl;
    end
  end

  task automatic chk1(input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int h;
    bit eb, ev, ed, ec, er;
    h = halves(m_ticks);
    eb = 0; ev = 0; ed = 0; ec = 0; er = 0;
    if (rst_n && m_st == 1) begin
      eb = 1; ev = (h >= 1); ed = (h >= 8);
      ec = m_latch | (h >= 8 && (!rst_req || h >= 14));
      er = (h >= 14) && rst_req;
    end else if (rst_n && m_st == 2) begin
      eb = (h < 10); ev = (m_ent >= 1) && (h < 3);
      ed = (m_ent >= 8) && (h < 2); ec = m_latch && (h < 1);
    end
    chk1("booster_en", booster_en, eb);
    chk1("vcc_en", vcc_en, ev);
    chk1("data_en", data_en, ed);
    chk1("clk_en", clk_en, ec);
    chk1("card_rst", card_rst, er);
    chk1("off_n", off_n, rst_n && m_pres && !m_flt);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  localparam int HT = HALF * TICK_DIV;  // cycles per half unit

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state and power-on hold
    tag = "R1"; cyc(3);
    rst_n = 1'b1; card_raw = 1'b1; cyc(DEB * TICK_DIV + 5);
    por_act = 1'b1; cyc(4); por_act = 1'b0;
    // R2: bouncing insertion, then steady
    tag = "R2";
    card_raw = 1'b0; cyc(3);
    for (int k = 0; k < 6; k++) begin
      card_raw = ~card_raw; cyc(int'($urandom % 20) + 1);
    end
    card_raw = 1'b1; cyc(DEB * TICK_DIV + 10);
    // R3/R4: activation with host reset low
    tag = "R3"; rst_req = 1'b0; start_n = 1'b0; cyc(3 * HT);
    tag = "R4"; cyc(13 * HT);
    rst_req = 1'b1; cyc(7); rst_req = 1'b0; cyc(5);
    // R6: commanded deactivation
    tag = "R6"; start_n = 1'b1; cyc(12 * HT);
    // R5: clock start gated by host reset
    tag = "R5"; rst_req = 1'b1; start_n = 1'b0;
    cyc(8 * HT + int'($urandom % (5 * HT)));
    rst_req = 1'b0; cyc(7 * HT);
    rst_req = 1'b1; cyc(9); rst_req = 1'b0; cyc(4);
    start_n = 1'b1; cyc(12 * HT);
    rst_req = 1'b1; start_n = 1'b0; cyc(16 * HT);
    rst_req = 1'b0; start_n = 1'b1; cyc(12 * HT);
    // R7: fault during session, then removal during session
    tag = "R7"; start_n = 1'b0; cyc(int'($urandom % (15 * HT)) + 2);
    fault_in = NF'(1 << ($urandom % NF)); cyc(1); fault_in = '0;
    cyc(12 * HT); start_n = 1'b1; cyc(4);
    start_n = 1'b0; cyc(10 * HT); card_raw = 1'b0; cyc(12 * HT);
    card_raw = 1'b1; start_n = 1'b1; cyc(DEB * TICK_DIV + 6);
    // R8: start during deactivation
    tag = "R8"; start_n = 1'b0; cyc(9 * HT); start_n = 1'b1; cyc(2 * HT);
    start_n = 1'b0; cyc(22 * HT); start_n = 1'b1; cyc(12 * HT);
    // R1: power-on reset in mid session
    tag = "R1"; start_n = 1'b0; cyc(9 * HT); por_act = 1'b1; cyc(3);
    por_act = 1'b0; start_n = 1'b1; cyc(DEB * TICK_DIV + 6);
    // R9: constrained random traffic
    tag = "R9";
    for (int k = 0; k < 5000; k++) begin
      if ($urandom % 60 == 0)  start_n = ~start_n;
      if ($urandom % 20 == 0)  rst_req = ~rst_req;
      if ($urandom % 250 == 0) card_raw = ~card_raw;
      fault_in = ($urandom % 400 == 0) ? NF'(1 << ($urandom % NF)) : '0;
      cyc(1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule